// File: doc/BRIEF.md
# Three-Tap Transmit Equalizer

This block is a symbol-rate digital model of the equalizer in a serial transmitter. Each accepted data bit becomes a symbol of value +1 (bit 1) or -1 (bit 0). The block weights three neighbouring symbols and produces a signed drive level in units of 1/FS, where FS is the full-swing parameter. The newest symbol is weighted by the pre-cursor, the one before it by the cursor, and the oldest by the post-cursor. The pre-cursor and post-cursor always act with a negative sign and the cursor with a positive sign. The result is a flat level during runs of equal bits, a pre-shoot level just before a polarity change, a de-emphasis level just after one, and a maximum-boost level on a one-UI inversion.

The three weights come from one of two sources. In preset mode a 4-bit index selects an entry of a built-in table: indices 0 to 10 are defined, and 11 to 15 are reserved. In direct mode three 6-bit magnitudes are used as given. A small state machine tracks which source is active. It has two states, `SRC_PRESET` and `SRC_DIRECT`, and three transitions: `keep` (the selection at a boundary names the current source, or the preset index is reserved), `to_direct` and `to_preset`. The state and the weights change only on a symbol strobe.

Top module: `txeq_fir3`

## Requirements
- R1: While reset is held and after it is released, `drive_lvl` is 0, and `drive_vld` and `preset_bad` are 0, until the first strobe.
- R2: On a clock edge with `sym_stb` high, `drive_lvl` becomes -pre·s(new) + cur·s(mid) - post·s(old), where s(1)=+1 and s(0)=-1. Here new is the bit on `sym_bit` at that edge, mid is the bit from the previous strobe, and old is the bit from the strobe before that. `drive_vld` is high in exactly the cycle after each strobe edge.
- R3: Preset indices 0 to 9 give magnitudes pre=round(a·FS) and post=round(b·FS), with halves rounded up, and cur=FS-pre-post. The ratios (a, b) by index are: 0:(0,0.250), 1:(0,0.167), 2:(0,0.200), 3:(0,0.125), 4:(0,0), 5:(0.100,0), 6:(0.125,0), 7:(0.100,0.200), 8:(0.125,0.125), 9:(0.167,0).
- R4: Preset index 10 gives pre=0, post=floor((FS-LF)/2) and cur=FS-post, so that the flat level sits at the low-frequency limit.
- R5: A strobe with `use_preset`=1 and an index from 11 to 15 leaves the weights and the source state unchanged, and raises `preset_bad` for the one cycle after that edge. Any other strobe, or no strobe, leaves `preset_bad` at 0.
- R6: A strobe with `use_preset`=0 applies `pre_mag`, `cur_mag` and `post_mag` as unsigned magnitudes. Pre and post are subtracted and cur is added, starting with the output of that same strobe.
- R7: The source select, the preset index and the direct magnitudes are sampled only at strobe edges. Between strobes, `drive_lvl` holds its value and `drive_vld` is 0, whatever the inputs do.
- R8: After reset the two stored symbols are -1. The weights start at preset 4 (pre=0, cur=FS, post=0) in state `SRC_PRESET`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sym_stb | input | 1 | Symbol boundary: accept `sym_bit` and sample the coefficient selection |
| sym_bit | input | 1 | Data bit; 1 maps to +1 and 0 maps to -1 |
| use_preset | input | 1 | 1 selects the preset table, 0 selects the direct magnitudes |
| preset_sel | input | 4 | Preset index; 11 to 15 are reserved |
| pre_mag | input | FS_W | Direct pre-cursor magnitude |
| cur_mag | input | FS_W | Direct cursor magnitude |
| post_mag | input | FS_W | Direct post-cursor magnitude |
| drive_lvl | output | FS_W+3 | Signed drive level in units of 1/FS |
| drive_vld | output | 1 | High for the cycle after each strobe |
| preset_bad | output | 1 | One-cycle flag for a reserved preset request |

## Verification
Every preset index and several direct settings are driven with a bit pattern that contains all eight three-bit windows. This exposes a design that swaps the pre-cursor and post-cursor taps, which would show pre-shoot where de-emphasis belongs, or that mis-rounds a table ratio. The first two outputs after reset show whether the stored symbols really start at -1; a line cleared to +1 would give the wrong sign on old taps. The reserved indices are applied after a non-default preset. A design that loaded zeros or the raw table slot would then lose that preset's levels, and a flag that stayed high or never rose would be caught. Finally, the selection inputs and the data bit are toggled with no strobe. A design that sampled them outside a boundary would change the output mid-sample.

// File: rtl/txeq_pkg.sv
package txeq_pkg;

    typedef enum logic [0:0] {
        SRC_PRESET = 1'b0,
        SRC_DIRECT = 1'b1
    } txeq_src_e;

    // Pre-cursor ratio in thousandths of full swing, by preset index
    function automatic int unsigned pre_milli(input int unsigned idx);
        case (idx)
            5:       return 100;
            6:       return 125;
            7:       return 100;
            8:       return 125;
            9:       return 167;
            default: return 0;
        endcase
    endfunction

    // Post-cursor ratio in thousandths of full swing, by preset index
    function automatic int unsigned post_milli(input int unsigned idx);
        case (idx)
            0:       return 250;
            1:       return 167;
            2:       return 200;
            3:       return 125;
            7:       return 200;
            8:       return 125;
            default: return 0;
        endcase
    endfunction

    function automatic int unsigned milli_to_units(input int unsigned milli,
                                                   input int unsigned fs);
        return (milli * fs + 500) / 1000;
    endfunction

endpackage

// File: rtl/txeq_delay_line.sv
module txeq_delay_line #(
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [DEPTH-1:0] taps
);

    logic [DEPTH-1:0] line_q;

    // bit value 0 stands for a -1 symbol
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_head
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)        line_q[g] <= 1'b0;
                    else if (shift_en) line_q[g] <= bit_in;
                end
            end else begin : g_body
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)        line_q[g] <= 1'b0;
                    else if (shift_en) line_q[g] <= line_q[g-1];
                end
            end
        end
    endgenerate

    assign taps = line_q;

    // R2: each stage takes the previous content of its neighbour
    a_r2_shift_order: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (taps[0] == $past(bit_in)));

endmodule

// File: rtl/txeq_coef_sel.sv
module txeq_coef_sel
    import txeq_pkg::*;
#(
    parameter int FS_W  = 6,
    parameter int FS    = 24,
    parameter int LF    = 8,
    parameter int IDX_W = 4,
    parameter int NUM_DEFINED = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_stb,
    input  logic             use_preset,
    input  logic [IDX_W-1:0] preset_sel,
    input  logic [FS_W-1:0]  dir_pre,
    input  logic [FS_W-1:0]  dir_cur,
    input  logic [FS_W-1:0]  dir_post,
    output logic [FS_W-1:0]  eff_pre,
    output logic [FS_W-1:0]  eff_cur,
    output logic [FS_W-1:0]  eff_post,
    output logic             bad_preset
);

    localparam int NUM_IDX   = 2 ** IDX_W;
    localparam int LF_INDEX  = NUM_DEFINED - 1;
    localparam int SUM_W     = FS_W + 2;

    logic [FS_W-1:0] tbl_pre  [NUM_IDX];
    logic [FS_W-1:0] tbl_cur  [NUM_IDX];
    logic [FS_W-1:0] tbl_post [NUM_IDX];

    generate
        for (genvar g = 0; g < NUM_IDX; g++) begin : g_tbl
            localparam int PRE_V  = (g >= LF_INDEX) ? 0 :
                                    int'(milli_to_units(pre_milli(g), FS));
            localparam int POST_V = (g > LF_INDEX)  ? 0 :
                                    (g == LF_INDEX) ? (FS - LF) / 2 :
                                    int'(milli_to_units(post_milli(g), FS));
            localparam int CUR_V  = (g > LF_INDEX) ? 0 : FS - PRE_V - POST_V;
            assign tbl_pre[g]  = FS_W'(PRE_V);
            assign tbl_cur[g]  = FS_W'(CUR_V);
            assign tbl_post[g] = FS_W'(POST_V);
        end
    endgenerate

    txeq_src_e       state_q, state_d;
    logic [FS_W-1:0] pre_q, cur_q, post_q;
    logic            bad_q;
    logic            idx_ok;
    logic            take_new;

    assign idx_ok   = (int'(preset_sel) < NUM_DEFINED);
    assign take_new = sym_stb && (!use_preset || idx_ok);

    // next-state process
    always_comb begin
        state_d = state_q;
        if (take_new) begin
            unique case (state_q)
                SRC_PRESET: if (!use_preset) state_d = SRC_DIRECT;  // to_direct
                SRC_DIRECT: if (use_preset)  state_d = SRC_PRESET;  // to_preset
                default:    state_d = SRC_PRESET;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SRC_PRESET;
        else        state_q <= state_d;
    end

    // output process: weights in force for this boundary
    always_comb begin
        eff_pre  = pre_q;
        eff_cur  = cur_q;
        eff_post = post_q;
        if (take_new) begin
            unique case (state_d)
                SRC_PRESET: begin
                    eff_pre  = tbl_pre[preset_sel];
                    eff_cur  = tbl_cur[preset_sel];
                    eff_post = tbl_post[preset_sel];
                end
                SRC_DIRECT: begin
                    eff_pre  = dir_pre;
                    eff_cur  = dir_cur;
                    eff_post = dir_post;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= '0;
            cur_q  <= FS_W'(FS);
            post_q <= '0;
            bad_q  <= 1'b0;
        end else begin
            pre_q  <= eff_pre;
            cur_q  <= eff_cur;
            post_q <= eff_post;
            bad_q  <= sym_stb && use_preset && !idx_ok;
        end
    end

    assign bad_preset = bad_q;

    // R3: preset weights always span the full swing
    a_r3_preset_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SRC_PRESET) |->
        (SUM_W'(pre_q) + SUM_W'(cur_q) + SUM_W'(post_q) == SUM_W'(FS)));

    // R5: a reserved request keeps weights and source
    a_r5_keep_coefs: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_stb && use_preset && !idx_ok) |=>
        ($stable(pre_q) && $stable(cur_q) && $stable(post_q) && $stable(state_q)));

    // R7: nothing moves without a strobe
    a_r7_no_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_stb |=> ($stable(pre_q) && $stable(state_q) && !bad_preset));

endmodule

// File: rtl/txeq_tap_sum.sv
module txeq_tap_sum #(
    parameter int FS_W  = 6,
    parameter int OUT_W = FS_W + 3
) (
    input  logic                    sym_new,
    input  logic                    sym_mid,
    input  logic                    sym_old,
    input  logic [FS_W-1:0]         w_pre,
    input  logic [FS_W-1:0]         w_cur,
    input  logic [FS_W-1:0]         w_post,
    output logic signed [OUT_W-1:0] level
);

    localparam int PAD = OUT_W - FS_W;

    logic signed [OUT_W-1:0] pre_s, cur_s, post_s;
    logic signed [OUT_W-1:0] t_pre, t_cur, t_post;

    always_comb begin
        pre_s  = $signed({{PAD{1'b0}}, w_pre});
        cur_s  = $signed({{PAD{1'b0}}, w_cur});
        post_s = $signed({{PAD{1'b0}}, w_post});
        // side taps carry a negative weight
        t_pre  = sym_new ? -pre_s  : pre_s;
        t_cur  = sym_mid ?  cur_s  : -cur_s;
        t_post = sym_old ? -post_s : post_s;
        level  = t_pre + t_cur + t_post;
    end

endmodule

// File: rtl/txeq_fir3.sv
module txeq_fir3
    import txeq_pkg::*;
#(
    parameter int FS_W = 6,
    parameter int FS   = 24,
    parameter int LF   = 8,
    parameter int OUT_W = FS_W + 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sym_stb,
    input  logic                    sym_bit,
    input  logic                    use_preset,
    input  logic [3:0]              preset_sel,
    input  logic [FS_W-1:0]         pre_mag,
    input  logic [FS_W-1:0]         cur_mag,
    input  logic [FS_W-1:0]         post_mag,
    output logic signed [OUT_W-1:0] drive_lvl,
    output logic                    drive_vld,
    output logic                    preset_bad
);

    localparam int HIST = 2;

    logic [HIST-1:0]         hist;
    logic [FS_W-1:0]         w_pre, w_cur, w_post;
    logic signed [OUT_W-1:0] level_c;
    logic signed [OUT_W-1:0] lvl_q;
    logic                    vld_q;

    txeq_coef_sel #(
        .FS_W(FS_W), .FS(FS), .LF(LF), .IDX_W(4), .NUM_DEFINED(11)
    ) coef_i (
        .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb),
        .use_preset(use_preset), .preset_sel(preset_sel),
        .dir_pre(pre_mag), .dir_cur(cur_mag), .dir_post(post_mag),
        .eff_pre(w_pre), .eff_cur(w_cur), .eff_post(w_post),
        .bad_preset(preset_bad)
    );

    txeq_delay_line #(.DEPTH(HIST)) line_i (
        .clk(clk), .rst_n(rst_n), .shift_en(sym_stb),
        .bit_in(sym_bit), .taps(hist)
    );

    txeq_tap_sum #(.FS_W(FS_W), .OUT_W(OUT_W)) sum_i (
        .sym_new(sym_bit), .sym_mid(hist[0]), .sym_old(hist[1]),
        .w_pre(w_pre), .w_cur(w_cur), .w_post(w_post),
        .level(level_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= sym_stb;
            if (sym_stb) lvl_q <= level_c;
        end
    end

    assign drive_lvl = lvl_q;
    assign drive_vld = vld_q;

    // R2: one valid cycle per strobe
    a_r2_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
        sym_stb |=> drive_vld);

    // R7: level frozen between strobes
    a_r7_hold_level: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_stb |=> ($stable(drive_lvl) && !drive_vld));

endmodule

// File: tb/txeq_fir3_tb_top.sv
module txeq_fir3_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int FS_W = 6;
    localparam int FS   = 24;
    localparam int LF   = 8;
    localparam int OUT_W = FS_W + 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sym_stb = 1'b0, sym_bit = 1'b0, use_preset = 1'b1;
    logic [3:0] preset_sel = 4'd4;
    logic [FS_W-1:0] pre_mag = '0, cur_mag = '0, post_mag = '0;
    logic signed [OUT_W-1:0] drive_lvl;
    logic drive_vld, preset_bad;

    int n_checks = 0, n_fail = 0;
    int m_pre = 0, m_cur = FS, m_post = 0;
    bit h_mid = 0, h_old = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txeq_fir3 #(.FS_W(FS_W), .FS(FS), .LF(LF)) dut_i (
        .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb), .sym_bit(sym_bit),
        .use_preset(use_preset), .preset_sel(preset_sel),
        .pre_mag(pre_mag), .cur_mag(cur_mag), .post_mag(post_mag),
        .drive_lvl(drive_lvl), .drive_vld(drive_vld), .preset_bad(preset_bad)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rnd(input int milli);
        return (milli * FS + 500) / 1000;
    endfunction

    // R3 and R4 weights from the stated ratios
    task automatic preset_model(input int idx, output int p, output int c, output int q);
        int pm [10] = '{0, 0, 0, 0, 0, 100, 125, 100, 125, 167};
        int qm [10] = '{250, 167, 200, 125, 0, 0, 0, 200, 125, 0};
        if (idx == 10) begin
            p = 0; q = (FS - LF) / 2;
        end else begin
            p = rnd(pm[idx]); q = rnd(qm[idx]);
        end
        c = FS - p - q;
    endtask

    function automatic int sg(input bit b);
        return b ? 1 : -1;
    endfunction

    // one strobe; sel_mode 1 = preset, 0 = direct
    task automatic push(input bit b, input bit up, input int idx,
                        input int dp, input int dc, input int dq,
                        input string req, input bit expect_bad);
        int exp;
        int p, c, q;
        @(negedge clk);
        sym_stb = 1'b1; sym_bit = b; use_preset = up;
        preset_sel = 4'(idx);
        pre_mag = FS_W'(dp); cur_mag = FS_W'(dc); post_mag = FS_W'(dq);
        if (!up) begin
            m_pre = dp; m_cur = dc; m_post = dq;
        end else if (idx <= 10) begin
            preset_model(idx, p, c, q);
            m_pre = p; m_cur = c; m_post = q;
        end
        exp = -m_pre * sg(b) + m_cur * sg(h_mid) - m_post * sg(h_old);
        h_old = h_mid; h_mid = b;
        @(posedge clk); #1;
        check(req, int'(drive_lvl), exp);
        check("R2 valid", int'(drive_vld), 1);
        check(expect_bad ? "R5 flag set" : "R5 flag clear", int'(preset_bad), int'(expect_bad));
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        sym_stb = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic sweep(input bit up, input int idx, input int dp,
                         input int dc, input int dq, input string req);
        bit pat [10] = '{0, 0, 0, 1, 0, 1, 1, 1, 0, 0};
        foreach (pat[i]) push(pat[i], up, idx, dp, dc, dq, req, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic signed [OUT_W-1:0] held;
        repeat (3) @(posedge clk);
        #1;
        check("R1 level in reset", int'(drive_lvl), 0);
        check("R1 vld in reset", int'(drive_vld), 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(posedge clk); #1;
        check("R1 level after reset", int'(drive_lvl), 0);
        check("R1 bad after reset", int'(preset_bad), 0);

        // R8: history starts at -1, default weights preset 4
        push(1'b1, 1'b1, 4, 0, 0, 0, "R8 first sym", 0);
        push(1'b1, 1'b1, 4, 0, 0, 0, "R8 second sym", 0);

        // R8 with side taps: fresh reset, then preset 7
        idle(1);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        h_mid = 0; h_old = 0; m_pre = 0; m_cur = FS; m_post = 0;
        push(1'b1, 1'b1, 7, 0, 0, 0, "R8 old taps -1", 0);

        // R3 / R4: every defined preset over all windows
        for (int k = 0; k <= 10; k++)
            sweep(1'b1, k, 0, 0, 0, (k == 10) ? "R4 preset 10" : "R3 preset");

        // R6: direct magnitudes
        sweep(1'b0, 0, 3, 15, 6, "R6 direct a");
        sweep(1'b0, 0, 0, 40, 0, "R6 direct b");
        sweep(1'b0, 0, 63, 63, 63, "R6 direct max");

        // R5: reserved after preset 7
        sweep(1'b1, 7, 0, 0, 0, "R3 preset 7");
        for (int k = 11; k <= 15; k++) begin
            push(1'b0, 1'b1, k, 0, 0, 0, "R5 keep weights", 1);
            push(1'b1, 1'b1, k, 0, 0, 0, "R5 keep weights", 1);
        end
        push(1'b0, 1'b1, 7, 0, 0, 0, "R5 valid after reserved", 0);
        idle(1); #1;
        check("R5 flag drops", int'(preset_bad), 0);

        // R7: inputs move without a strobe
        held = drive_lvl;
        @(negedge clk);
        sym_bit = 1'b1; use_preset = 1'b0; pre_mag = 6'd50; cur_mag = 6'd1; preset_sel = 4'd13;
        repeat (3) @(posedge clk);
        #1;
        check("R7 level held", int'(drive_lvl), int'(held));
        check("R7 vld low", int'(drive_vld), 0);
        check("R7 bad low", int'(preset_bad), 0);
        // selection not sampled between strobes: preset 7 still active
        push(1'b1, 1'b1, 15, 0, 0, 0, "R7 weights unchanged", 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule